// File: doc/BRIEF.md
# Triggered ADC Channel Sequencer

This block decides which analog channel a converter core samples next. It keeps two independent channel lists. The regular list holds up to sixteen slots. The injected list holds one to four slots. Trigger pulses step the block through these lists, and mode inputs choose how each list is walked.

The converter core is seen only through a small handshake. The block pulses a start strobe and presents a channel number. It then holds that number until the core reports completion or until the block cancels the conversion. Each finished conversion raises sticky status flags, which software clears by pulsing a write-one-to-clear input. For injected conversions, the block also reports which injected result slot the data belongs to.

The regular list can be walked in three ways:
- one pass per trigger;
- endlessly in continuous mode;
- in short bursts of N slots per trigger.

The injected list can be walked in three ways:
- all at once on its own trigger;
- one slot per trigger;
- automatically, right after each regular pass.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `core_start` is a one-cycle pulse. `core_chan` holds its value from that pulse until the core answers or the block cancels. At most one conversion is outstanding. A new start comes no earlier than the cycle after `core_done` or `core_abort`.
- R2: With continuous and burst modes off, one regular trigger converts slots 0 to `reg_len` in ascending order. Conversion then stops.
- R3: In continuous mode, a new regular pass starts from slot 0 as soon as a pass ends. When burst mode is on, continuous mode has no effect.
- R4: In burst mode, each regular trigger converts `reg_disc_num`+1 consecutive slots, starting after the last slot converted. A burst is cut short at the end of the list, and the next trigger starts again from slot 0.
- R5: An injected trigger converts injected slots 0 to `inj_len` in order. `inj_rslot` gives the index of the slot being converted, valid from `core_start` onward.
- R6: With `inj_disc_en` set, each injected trigger converts exactly one injected slot, and the slot index wraps to 0 after slot `inj_len`.
- R7: With `inj_auto` set, the injected group starts by itself after each completed regular pass, and `inj_trig` has no effect.
- R8: While the injected group is active, it is served before any further regular conversion. A regular trigger that arrives meanwhile is held and serviced afterwards, so it is not lost.
- R9: A trigger for a group that is already active is ignored.
- R10: Pulsing `inj_seq_wr` during an injected conversion cancels it with a one-cycle `core_abort` and restarts the injected group at slot 0. No conversion is launched in a cycle where `inj_seq_wr` is high.
- R11: The flag bits are sticky:
  - bit 0 sets after each regular conversion;
  - bit 1 sets after the last regular slot is converted;
  - bit 2 sets after each injected conversion;
  - bit 3 sets after the last injected slot is converted.
- R12: A 1 in `flag_clr` clears the matching flag bit. When a set event and a clear for the same bit fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_trig | input | 1 | Regular group trigger pulse |
| inj_trig | input | 1 | Injected group trigger pulse |
| reg_len | input | 4 | Regular list length minus one |
| reg_slots | input | 80 | Regular channels, slot i in bits [5i+4:5i], values 0..18 |
| inj_len | input | 2 | Injected list length minus one |
| inj_slots | input | 20 | Injected channels, slot j in bits [5j+4:5j], values 0..18 |
| inj_seq_wr | input | 1 | Pulse that marks a rewrite of the injected list |
| cont_mode | input | 1 | Continuous regular passes |
| reg_disc_en | input | 1 | Regular burst mode |
| reg_disc_num | input | 3 | Burst length minus one |
| inj_disc_en | input | 1 | Injected one-slot-per-trigger mode |
| inj_auto | input | 1 | Chain the injected group after each regular pass |
| flag_clr | input | 4 | Write-one-to-clear for the flag bits |
| core_done | input | 1 | Converter core finished the current conversion |
| core_start | output | 1 | Start pulse to the converter core |
| core_chan | output | 5 | Channel of the current conversion |
| core_abort | output | 1 | Cancel pulse for the current conversion |
| inj_rslot | output | 2 | Injected result slot of the latest injected conversion |
| flags | output | 4 | Sticky status flags |

## Verification
Two pairs of functions can meet in a single cycle.

The first pair is the flag set and the software clear. The bench's converter model pulses `flag_clr` with all ones in the very cycle it raises `core_done` on a one-slot regular pass, while the injected flags are already set. The regular flags must survive and the injected flags must be cleared.

The second pair is a regular trigger and an injected group. The bench fires a regular trigger one cycle after an injected trigger, and in a separate run fires an injected trigger in the middle of a regular pass. The scoreboard then checks the exact order of channels that reaches the core.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CHAN_W      = 5;
  localparam int FLG_N       = 4;
  localparam int FLG_REG_EOC = 0;
  localparam int FLG_REG_EOS = 1;
  localparam int FLG_INJ_EOC = 2;
  localparam int FLG_INJ_EOS = 3;

  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;
endpackage

// File: rtl/seq_reg_cursor.sv
module seq_reg_cursor #(
  parameter int SLOTS     = 16,
  parameter int BURST_MAX = 8,
  localparam int PW = $clog2(SLOTS),
  localparam int BW = $clog2(BURST_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          step,
  input  logic [PW-1:0] len,
  input  logic          disc_en,
  input  logic [BW-1:0] disc_num,
  input  logic          cont,
  output logic          active,
  output logic [PW-1:0] pos,
  output logic          pass_end
);
  logic          act_q, act_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [BW-1:0] bur_q, bur_d;
  logic          last_slot, last_burst, accept, upd;

  always_comb begin
    last_slot  = (pos_q == len);
    last_burst = disc_en && (bur_q == disc_num);
    accept     = trig && !act_q;
    act_d      = act_q;
    pos_d      = pos_q;
    bur_d      = bur_q;
    if (accept) begin
      act_d = 1'b1;
      bur_d = '0;
      if (!disc_en) pos_d = '0;
    end else if (step) begin
      pos_d = last_slot ? '0 : pos_q + 1'b1;
      bur_d = (!disc_en || last_slot || last_burst) ? '0 : bur_q + 1'b1;
      if (disc_en) act_d = !(last_slot || last_burst);
      else         act_d = last_slot ? cont : 1'b1;
    end
    upd = accept || step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pos_q <= '0;
      bur_q <= '0;
    end else if (upd) begin
      act_q <= act_d;
      pos_q <= pos_d;
      bur_q <= bur_d;
    end
  end

  assign active   = act_q;
  assign pos      = pos_q;
  assign pass_end = step && last_slot;

  // R9
  reg_trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig && act_q && !step |=> act_q && $stable(pos_q));
  // R4
  reg_burst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && disc_en && last_burst |=> !act_q);
  // R2
  reg_single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !disc_en && !cont && last_slot |=> !act_q && pos_q == '0);
endmodule

// File: rtl/seq_inj_cursor.sv
module seq_inj_cursor #(
  parameter int SLOTS = 4,
  localparam int PW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          auto_start,
  input  logic          auto_en,
  input  logic          restart,
  input  logic          step,
  input  logic [PW-1:0] len,
  input  logic          disc_en,
  output logic          active,
  output logic [PW-1:0] pos,
  output logic          grp_end
);
  logic          act_q, act_d;
  logic [PW-1:0] pos_q, pos_d;
  logic          last, launch, upd;

  always_comb begin
    last   = (pos_q == len);
    launch = !act_q && (auto_en ? auto_start : trig);
    act_d  = act_q;
    pos_d  = pos_q;
    if (launch) begin
      act_d = 1'b1;
      if (!disc_en) pos_d = '0;
    end
    if (step) begin
      pos_d = last ? '0 : pos_q + 1'b1;
      act_d = disc_en ? 1'b0 : !last;
    end
    if (restart) pos_d = '0;
    upd = launch || step || restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pos_q <= '0;
    end else if (upd) begin
      act_q <= act_d;
      pos_q <= pos_d;
    end
  end

  assign active  = act_q;
  assign pos     = pos_q;
  assign grp_end = step && last;

  // R10
  inj_restart_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pos_q == '0);
  // R7
  inj_auto_blocks_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && !auto_start && !act_q |=> !act_q);
  // R6
  inj_one_per_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && disc_en |=> !act_q);
endmodule

// File: rtl/seq_conv_arb.sv
module seq_conv_arb
  import adc_seq_pkg::*;
#(
  parameter int CHW = CHAN_W,
  parameter int IPW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_req,
  input  logic           inj_req,
  input  logic [CHW-1:0] reg_chan,
  input  logic [CHW-1:0] inj_chan,
  input  logic [IPW-1:0] inj_pos,
  input  logic           hold,
  input  logic           core_done,
  output logic           core_start,
  output logic [CHW-1:0] core_chan,
  output logic           core_abort,
  output logic [IPW-1:0] inj_rslot,
  output logic           step_reg,
  output logic           step_inj
);
  arb_state_e     state_q, state_d;
  logic           cur_inj_q, cur_inj_d;
  logic           start_q, start_d, abort_q, abort_d;
  logic [CHW-1:0] chan_q, chan_d;
  logic [IPW-1:0] rslot_q, rslot_d;

  always_comb begin
    state_d   = state_q;
    cur_inj_d = cur_inj_q;
    start_d   = 1'b0;
    abort_d   = 1'b0;
    chan_d    = chan_q;
    rslot_d   = rslot_q;
    step_reg  = 1'b0;
    step_inj  = 1'b0;
    case (state_q)
      ARB_IDLE: begin
        if (!hold && (inj_req || reg_req)) begin
          state_d   = ARB_BUSY;
          start_d   = 1'b1;
          cur_inj_d = inj_req;
          chan_d    = inj_req ? inj_chan : reg_chan;
          if (inj_req) rslot_d = inj_pos;
        end
      end
      ARB_BUSY: begin
        if (cur_inj_q && hold) begin
          abort_d = 1'b1;
          state_d = ARB_IDLE;
        end else if (core_done) begin
          state_d  = ARB_IDLE;
          step_reg = !cur_inj_q;
          step_inj = cur_inj_q;
        end
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ARB_IDLE;
      cur_inj_q <= 1'b0;
      start_q   <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      cur_inj_q <= cur_inj_d;
      start_q   <= start_d;
      abort_q   <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      rslot_q <= '0;
    end else if (start_d) begin
      chan_q  <= chan_d;
      rslot_q <= rslot_d;
    end
  end

  assign core_start = start_q;
  assign core_abort = abort_q;
  assign core_chan  = chan_q;
  assign inj_rslot  = rslot_q;

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  // R1
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> $stable(core_chan));
  // R1
  start_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !core_abort);
  // R8
  inj_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ARB_IDLE && inj_req && !hold |=> core_start && cur_inj_q);
  // R10
  hold_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !core_start);
endmodule

// File: rtl/seq_flags.sv
module seq_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flg_q, flg_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb flg_d[i] = set[i] | (flg_q[i] & ~clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flg_q[i] <= 1'b0;
      else if (set[i] || clr[i]) flg_q[i] <= flg_d[i];
    end

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]);
    // R12
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] && !set[i] |=> !flags[i]);
    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && !clr[i] |=> flags[i]);
  end

  assign flags = flg_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int REG_SLOTS = 16,
  parameter int INJ_SLOTS = 4,
  parameter int BURST_MAX = 8,
  parameter int CHW       = CHAN_W,
  localparam int RPW = $clog2(REG_SLOTS),
  localparam int IPW = $clog2(INJ_SLOTS),
  localparam int BNW = $clog2(BURST_MAX)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_trig,
  input  logic                     inj_trig,
  input  logic [RPW-1:0]           reg_len,
  input  logic [REG_SLOTS*CHW-1:0] reg_slots,
  input  logic [IPW-1:0]           inj_len,
  input  logic [INJ_SLOTS*CHW-1:0] inj_slots,
  input  logic                     inj_seq_wr,
  input  logic                     cont_mode,
  input  logic                     reg_disc_en,
  input  logic [BNW-1:0]           reg_disc_num,
  input  logic                     inj_disc_en,
  input  logic                     inj_auto,
  input  logic [FLG_N-1:0]         flag_clr,
  input  logic                     core_done,
  output logic                     core_start,
  output logic [CHW-1:0]           core_chan,
  output logic                     core_abort,
  output logic [IPW-1:0]           inj_rslot,
  output logic [FLG_N-1:0]         flags
);
  logic           reg_act, inj_act, reg_end, inj_end;
  logic           step_reg, step_inj;
  logic [RPW-1:0] reg_pos;
  logic [IPW-1:0] inj_pos;
  logic [CHW-1:0] reg_chan, inj_chan;
  logic [FLG_N-1:0] flag_set;

  assign reg_chan = reg_slots[reg_pos*CHW +: CHW];
  assign inj_chan = inj_slots[inj_pos*CHW +: CHW];

  seq_reg_cursor #(.SLOTS(REG_SLOTS), .BURST_MAX(BURST_MAX)) u_reg (
    .clk(clk), .rst_n(rst_n), .trig(reg_trig), .step(step_reg),
    .len(reg_len), .disc_en(reg_disc_en), .disc_num(reg_disc_num),
    .cont(cont_mode), .active(reg_act), .pos(reg_pos), .pass_end(reg_end));

  seq_inj_cursor #(.SLOTS(INJ_SLOTS)) u_inj (
    .clk(clk), .rst_n(rst_n), .trig(inj_trig), .auto_start(reg_end),
    .auto_en(inj_auto), .restart(inj_seq_wr), .step(step_inj),
    .len(inj_len), .disc_en(inj_disc_en), .active(inj_act),
    .pos(inj_pos), .grp_end(inj_end));

  seq_conv_arb #(.CHW(CHW), .IPW(IPW)) u_arb (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_act), .inj_req(inj_act),
    .reg_chan(reg_chan), .inj_chan(inj_chan), .inj_pos(inj_pos),
    .hold(inj_seq_wr), .core_done(core_done), .core_start(core_start),
    .core_chan(core_chan), .core_abort(core_abort), .inj_rslot(inj_rslot),
    .step_reg(step_reg), .step_inj(step_inj));

  always_comb begin
    flag_set              = '0;
    flag_set[FLG_REG_EOC] = step_reg;
    flag_set[FLG_REG_EOS] = reg_end;
    flag_set[FLG_INJ_EOC] = step_inj;
    flag_set[FLG_INJ_EOS] = inj_end;
  end

  seq_flags #(.N(FLG_N)) u_flg (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags(flags));
endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int LAT = 3;

  typedef struct packed {
    logic       inj;
    logic [4:0] chan;
    logic [1:0] rslot;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_trig = 0, inj_trig = 0, inj_seq_wr = 0;
  logic [3:0]  reg_len = 0;
  logic [79:0] reg_slots;
  logic [1:0]  inj_len = 0;
  logic [19:0] inj_slots;
  logic        cont_mode = 0, reg_disc_en = 0, inj_disc_en = 0, inj_auto = 0;
  logic [2:0]  reg_disc_num = 0;
  logic [3:0]  clr_a = 0, clr_b = 0, flag_clr;
  logic        core_done = 0;
  logic        core_start, core_abort;
  logic [4:0]  core_chan;
  logic [1:0]  inj_rslot;
  logic [3:0]  flags;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_fail = 0;
  int    core_busy = 0, abort_cnt = 0, start_cnt = 0;
  bit    collide_en = 0;
  exp_t  mon_e;
  string mon_t;

  assign flag_clr = clr_a | clr_b;

  always #4 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_trig(reg_trig), .inj_trig(inj_trig),
    .reg_len(reg_len), .reg_slots(reg_slots), .inj_len(inj_len),
    .inj_slots(inj_slots), .inj_seq_wr(inj_seq_wr), .cont_mode(cont_mode),
    .reg_disc_en(reg_disc_en), .reg_disc_num(reg_disc_num),
    .inj_disc_en(inj_disc_en), .inj_auto(inj_auto), .flag_clr(flag_clr),
    .core_done(core_done), .core_start(core_start), .core_chan(core_chan),
    .core_abort(core_abort), .inj_rslot(inj_rslot), .flags(flags));

  function automatic logic [4:0] reg_ch(int i);
    return 5'((i * 7 + 1) % 15);
  endfunction

  function automatic logic [4:0] inj_ch(int j);
    return 5'(15 + j);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push_reg(int s, string tag);
    exp_q.push_back({1'b0, reg_ch(s), 2'b00});
    tag_q.push_back(tag);
  endtask

  task automatic push_inj(int s, string tag);
    exp_q.push_back({1'b1, inj_ch(s), 2'(s)});
    tag_q.push_back(tag);
  endtask

  task automatic drain(string tag);
    int t = 0;
    while ((exp_q.size() != 0 || core_busy != 0) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, tag, "pending conversions", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic pulse_reg();
    @(negedge clk) reg_trig = 1'b1;
    @(negedge clk) reg_trig = 1'b0;
  endtask

  task automatic pulse_inj();
    @(negedge clk) inj_trig = 1'b1;
    @(negedge clk) inj_trig = 1'b0;
  endtask

  task automatic clr_all();
    @(negedge clk) clr_a = 4'hF;
    @(negedge clk) clr_a = 4'h0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor: every start is compared against the expected queue
  always @(negedge clk) begin
    if (rst_n && core_start) begin
      start_cnt++;
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R9 unexpected start actual=%0d expected=none", core_chan);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(core_chan == mon_e.chan, mon_t, "channel", core_chan, mon_e.chan);
        if (mon_e.inj)
          check(inj_rslot == mon_e.rslot, mon_t, "result slot", inj_rslot, mon_e.rslot);
      end
    end
  end

  // converter core model
  always @(negedge clk) begin
    core_done <= 1'b0;
    clr_b     <= 4'h0;
    if (!rst_n) begin
      core_busy = 0;
    end else if (core_abort) begin
      core_busy = 0;
      abort_cnt++;
    end else if (core_start) begin
      check(core_busy == 0, "R1", "start while busy", core_busy, 0);
      core_busy = LAT;
    end else if (core_busy > 0) begin
      core_busy--;
      if (core_busy == 0) begin
        core_done <= 1'b1;
        if (collide_en) clr_b <= 4'hF;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int sc, ac;
    for (int i = 0; i < 16; i++) reg_slots[i*5 +: 5] = reg_ch(i);
    for (int j = 0; j < 4; j++)  inj_slots[j*5 +: 5] = inj_ch(j);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags == 4'h0, "R11", "reset flags", flags, 0);
    check(core_start == 1'b0 && core_abort == 1'b0, "R1", "reset strobes",
          {core_start, core_abort}, 0);

    // R2 single pass of five slots
    reg_len = 4'd4;
    for (int s = 0; s < 5; s++) push_reg(s, "R2");
    pulse_reg();
    @(negedge clk) reg_trig = 1'b1;  // R9 retrigger while busy
    @(negedge clk) reg_trig = 1'b0;
    drain("R2");
    check(flags == 4'b0011, "R11", "regular flags", flags, 4'b0011);
    clr_all();
    check(flags == 4'h0, "R12", "clear", flags, 0);

    // R4 bursts of three over seven slots
    reg_len = 4'd6; reg_disc_en = 1'b1; reg_disc_num = 3'd2;
    for (int s = 0; s < 3; s++) push_reg(s, "R4");
    pulse_reg(); drain("R4");
    check(flags == 4'b0001, "R4", "flags after burst 1", flags, 4'b0001);
    for (int s = 3; s < 6; s++) push_reg(s, "R4");
    pulse_reg(); drain("R4");
    check(flags == 4'b0001, "R4", "flags after burst 2", flags, 4'b0001);
    push_reg(6, "R4");
    pulse_reg(); drain("R4");
    check(flags == 4'b0011, "R4", "flags after short burst", flags, 4'b0011);
    for (int s = 0; s < 3; s++) push_reg(s, "R4");
    pulse_reg(); drain("R4");
    reg_disc_en = 1'b0;
    clr_all();

    // R3 continuous passes over two slots, stopped after the third pass
    reg_len = 4'd1; cont_mode = 1'b1;
    for (int p = 0; p < 3; p++) begin push_reg(0, "R3"); push_reg(1, "R3"); end
    pulse_reg();
    while (exp_q.size() > 1) @(negedge clk);
    cont_mode = 1'b0;
    drain("R3");
    clr_all();

    // R5 injected group of three
    inj_len = 2'd2;
    for (int s = 0; s < 3; s++) push_inj(s, "R5");
    pulse_inj(); drain("R5");
    check(flags == 4'b1100, "R5", "injected flags", flags, 4'b1100);
    clr_all();

    // R6 injected one slot per trigger over two slots
    inj_len = 2'd1; inj_disc_en = 1'b1;
    push_inj(0, "R6"); pulse_inj(); drain("R6");
    check(flags == 4'b0100, "R6", "flags after slot 0", flags, 4'b0100);
    push_inj(1, "R6"); pulse_inj(); drain("R6");
    check(flags == 4'b1100, "R6", "flags after slot 1", flags, 4'b1100);
    push_inj(0, "R6"); pulse_inj(); drain("R6");
    inj_disc_en = 1'b0;
    clr_all();

    // R10 rewrite during the second injected conversion
    inj_len = 2'd2;
    ac = abort_cnt;
    push_inj(0, "R10"); push_inj(1, "R10");
    for (int s = 0; s < 3; s++) push_inj(s, "R10");
    pulse_inj();
    while (exp_q.size() > 3) @(negedge clk);
    inj_seq_wr = 1'b1;
    @(negedge clk) inj_seq_wr = 1'b0;
    drain("R10");
    check(abort_cnt == ac + 1, "R10", "abort pulses", abort_cnt - ac, 1);
    clr_all();

    // R7 auto chaining, then an ignored injected trigger
    inj_auto = 1'b1; reg_len = 4'd1; inj_len = 2'd1;
    push_reg(0, "R7"); push_reg(1, "R7"); push_inj(0, "R7"); push_inj(1, "R7");
    pulse_reg(); drain("R7");
    sc = start_cnt;
    pulse_inj(); drain("R7");
    check(start_cnt == sc, "R7", "starts after injected trigger", start_cnt - sc, 0);
    inj_auto = 1'b0;
    clr_all();

    // R8 injected trigger in the middle of a regular pass
    reg_len = 4'd3; inj_len = 2'd2;
    push_reg(0, "R8");
    for (int s = 0; s < 3; s++) push_inj(s, "R8");
    for (int s = 1; s < 4; s++) push_reg(s, "R8");
    pulse_reg();
    while (exp_q.size() > 6) @(negedge clk);
    pulse_inj(); drain("R8");

    // R8 regular trigger held while the injected group runs
    for (int s = 0; s < 3; s++) push_inj(s, "R8");
    for (int s = 0; s < 4; s++) push_reg(s, "R8");
    pulse_inj(); pulse_reg(); drain("R8");
    check(flags == 4'hF, "R11", "all flags", flags, 4'hF);

    // R12 clear arrives in the same cycle as the regular set events
    clr_all();
    inj_len = 2'd0; push_inj(0, "R12"); pulse_inj(); drain("R12");
    reg_len = 4'd0; collide_en = 1'b1;
    push_reg(0, "R12"); pulse_reg(); drain("R12");
    collide_en = 1'b0;
    check(flags == 4'b0011, "R12", "set wins over clear", flags, 4'b0011);
    clr_all();
    check(flags == 4'h0, "R12", "final clear", flags, 0);

    finish_run();
  end
endmodule